// File: doc/BRIEF.md
# Video Control Glitch Filter

This block sits in front of a display-link encoder and cleans up the three low-rate timing strobes of a video stream: data enable, horizontal sync and vertical sync. It samples them on every pixel clock and forwards a level change only when the change is credible. Each strobe has a budget of forwarded transitions over a sliding window of 130 pixel clocks. When the filter is switched on, a new level must also hold for three consecutive samples before it is forwarded. Changes that fail either rule are discarded, and the output keeps its last level.

A two-bit configuration input picks one of four modes. Two legacy modes pass the strobes through without any limit. One normal mode applies only the transition budgets. The other normal mode applies the budgets and the three-sample persistence rule. All three outputs come from registers and share one latency, so they stay aligned with each other and with the pixel data that the encoder delays by the same amount. The strobes take one sample per clock with no valid/ready handshake and no back-pressure. The encoder downstream must consume every output sample.

Top module: `vid_ctrl_filter`

## Requirements
- R1: `mode` is decoded as follows. 2'b00 and 2'b01 are legacy pass-through modes. 2'b10 is normal mode with the filter off. 2'b11 is normal mode with the filter on.
- R2: In both legacy modes, each output equals its input as sampled two clock edges earlier. No transition limit applies.
- R3: In mode 2'b10 a new input level reaches the output one edge after the level is first captured. A single-cycle pulse is therefore forwarded whenever the budget allows it.
- R4: In the normal modes, `de_out` and `hs_out` each change at most twice in any 130 consecutive cycles. A third change is accepted no earlier than 130 edges after the earlier of the two previous accepted changes.
- R5: In the normal modes, consecutive changes of `vs_out` are at least 130 edges apart. Every forwarded vertical-sync pulse is therefore at least 130 cycles wide.
- R6: In mode 2'b11 a new level of any strobe is forwarded only after it has been captured on three consecutive edges. Pulses of one or two cycles are dropped.
- R7: In mode 2'b11 every output lags its input by a fixed four cycles. Changes applied to all three inputs at once therefore appear on all three outputs in the same cycle.
- R8: A rejected change leaves the output at its previous level. If the input keeps the new level, that level is forwarded at the first edge at which the budget permits it.
- R9: While `rst_n` is low, each output is loaded from its input on every edge and all budgets are cleared. The first qualified change after reset is therefore always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode (see R1) |
| de_in | input | 1 | Raw data-enable strobe |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| de_out | output | 1 | Filtered data enable |
| hs_out | output | 1 | Filtered horizontal sync |
| vs_out | output | 1 | Filtered vertical sync |

## Verification
An input driven before edge k is captured at edge k. It reaches the outputs at edge k+1 in the legacy modes and in mode 2'b10, and at edge k+3 in mode 2'b11. A change held back by a budget appears at a later edge that the bench computes from the times of earlier accepted changes. For every edge, the driver task works out the expected output triple from a timestamp model of the requirements and queues it with the number of the edge it belongs to. The monitor compares the outputs at the falling edge that follows that edge, so each check lands in the cycle in which its result is due and never on a clock edge.

// File: rtl/vcf_pkg.sv
package vcf_pkg;

  typedef enum logic [1:0] {
    MODE_LEGACY_A    = 2'b00,
    MODE_LEGACY_B    = 2'b01,
    MODE_NORMAL_RAW  = 2'b10,
    MODE_NORMAL_FILT = 2'b11
  } vcf_mode_e;

  localparam int unsigned LANES   = 3;
  localparam int unsigned LANE_DE = 0;
  localparam int unsigned LANE_HS = 1;
  localparam int unsigned LANE_VS = 2;

endpackage

// File: rtl/vcf_qualify.sv
// Persistence check: keeps the last DEPTH samples of one strobe.
module vcf_qualify #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic long_i,
  output logic cand_ok,
  output logic cand_lvl
);

  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= {DEPTH{sig_i}};
    else        hist_q <= {hist_q[DEPTH-2:0], sig_i};
  end

  // Newest sample is the candidate; in long mode all samples must agree (R6)
  assign cand_lvl = hist_q[0];
  assign cand_ok  = long_i ? ((&hist_q) || (~|hist_q)) : 1'b1;

endmodule

// File: rtl/vcf_budget.sv
// Transition budget: SLOTS age counters, a one-hot pointer marks the oldest.
module vcf_budget #(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned WINDOW = 130
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic room_o
);

  localparam int unsigned CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(WINDOW - 1);

  logic [SLOTS-1:0] sel_q;
  logic [SLOTS-1:0] idle;

  generate
    if (SLOTS == 1) begin : g_one
      assign sel_q = 1'b1;
    end else begin : g_ring
      always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= SLOTS'(1);
        else if (take_i) sel_q <= {sel_q[SLOTS-2:0], sel_q[SLOTS-1]};
      end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [CW-1:0] age_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                 age_q <= '0;
        else if (take_i && sel_q[s]) age_q <= RELOAD;
        else if (age_q != '0)       age_q <= age_q - 1'b1;
      end
      assign idle[s] = (age_q == '0);
    end
  endgenerate

  // A new change is allowed once the oldest recorded change has aged out (R4, R5)
  assign room_o = |(sel_q & idle);

endmodule

// File: rtl/vcf_lane.sv
// One strobe: qualification, budget and the output register.
module vcf_lane #(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned WINDOW = 130,
  parameter int unsigned QDEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic long_i,
  input  logic limit_i,
  output logic sig_o
);

  localparam int unsigned AW = $clog2(WINDOW + 1);
  localparam logic [AW-1:0] GAP_FULL = AW'(WINDOW);

  logic cand_ok, cand_lvl, room;
  logic want, take, accept;
  logic out_q;

  vcf_qualify #(.DEPTH(QDEPTH)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig_i   (sig_i),
    .long_i  (long_i),
    .cand_ok (cand_ok),
    .cand_lvl(cand_lvl)
  );

  vcf_budget #(.SLOTS(SLOTS), .WINDOW(WINDOW)) u_bud (
    .clk   (clk),
    .rst_n (rst_n),
    .take_i(take),
    .room_o(room)
  );

  always_comb begin
    want   = cand_ok && (cand_lvl != out_q);
    take   = want && limit_i && room;
    accept = want && (!limit_i || room);
  end

  // Rejected changes leave the level untouched (R8); reset loads the input (R9)
  always_ff @(posedge clk) begin
    if (!rst_n)      out_q <= sig_i;
    else if (accept) out_q <= cand_lvl;
  end

  assign sig_o = out_q;

  // Checker: independent record of the spacing between output changes
  logic prev_q;
  logic moved;
  logic [AW-1:0] gap_q [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= sig_i;
    else        prev_q <= out_q;
  end
  assign moved = (out_q != prev_q);

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_gap
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n || !limit_i) gap_q[s] <= GAP_FULL;
          else if (moved)         gap_q[s] <= AW'(1);
          else if (gap_q[s] != GAP_FULL) gap_q[s] <= gap_q[s] + 1'b1;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n || !limit_i) gap_q[s] <= GAP_FULL;
          else if (moved)         gap_q[s] <= (gap_q[s-1] == GAP_FULL) ? GAP_FULL : gap_q[s-1] + 1'b1;
          else if (gap_q[s] != GAP_FULL) gap_q[s] <= gap_q[s] + 1'b1;
        end
      end
    end
  endgenerate

  // R4 (SLOTS=2) and R5 (SLOTS=1): the change SLOTS back lies a full window ago
  a_r4_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && limit_i) |-> (gap_q[SLOTS-1] >= GAP_FULL));

endmodule

// File: rtl/vid_ctrl_filter.sv
module vid_ctrl_filter
  import vcf_pkg::*;
#(
  parameter int unsigned WINDOW      = 130,
  parameter int unsigned FAST_BUDGET = 2,
  parameter int unsigned SLOW_BUDGET = 1,
  parameter int unsigned QUAL_DEPTH  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       de_in,
  input  logic       hs_in,
  input  logic       vs_in,
  output logic       de_out,
  output logic       hs_out,
  output logic       vs_out
);

  vcf_mode_e mode_e;
  logic limit_en, filt_en, legacy;
  logic [LANES-1:0] in_v, out_v;

  // R1: mode decode
  always_comb begin
    mode_e   = vcf_mode_e'(mode);
    filt_en  = (mode_e == MODE_NORMAL_FILT);
    limit_en = (mode_e == MODE_NORMAL_RAW) || filt_en;
    legacy   = (mode_e == MODE_LEGACY_A) || (mode_e == MODE_LEGACY_B);
  end

  assign in_v = {vs_in, hs_in, de_in};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int unsigned SLOTS = (g == LANE_VS) ? SLOW_BUDGET : FAST_BUDGET;
      vcf_lane #(.SLOTS(SLOTS), .WINDOW(WINDOW), .QDEPTH(QUAL_DEPTH)) u_lane (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (in_v[g]),
        .long_i (filt_en),
        .limit_i(limit_en),
        .sig_o  (out_v[g])
      );
    end
  endgenerate

  assign de_out = out_v[LANE_DE];
  assign hs_out = out_v[LANE_HS];
  assign vs_out = out_v[LANE_VS];

  // R2: legacy modes are a plain two-edge delay
  a_r2_compat_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && $past(legacy) && $past(legacy, 2) && $past(rst_n))
      |-> (out_v == $past(in_v, 2)));

  // R9: the first edge out of reset shows the inputs sampled during reset
  a_r9_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_v == $past(in_v)));

  // R6: with the filter on, a forwarded level was present on three captures
  generate
    if (QUAL_DEPTH == 3) begin : g_run_chk
      for (genvar b = 0; b < LANES; b++) begin : g_bit
        a_r6_min_run: assert property (@(posedge clk) disable iff (!rst_n)
          (filt_en && $past(filt_en) && $past(filt_en, 2) && $past(filt_en, 3)
           && $past(rst_n) && !$stable(out_v[b]))
            |-> (($past(in_v[b], 2) == out_v[b]) && ($past(in_v[b], 3) == out_v[b])
                 && ($past(in_v[b], 4) == out_v[b])));
      end
    end
  endgenerate

endmodule

// File: tb/tb_vid_ctrl_filter.sv
module tb_vid_ctrl_filter;

  localparam int WIN = 130;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] next_mode = 2'b00;
  logic       de_i = 1'b0, hs_i = 1'b0, vs_i = 1'b0;
  logic       de_o, hs_o, vs_o;

  vid_ctrl_filter dut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .de_in(de_i), .hs_in(hs_i), .vs_in(vs_i),
    .de_out(de_o), .hs_out(hs_o), .vs_out(vs_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [2:0] exp;
    int         due;
    string      tag;
  } item_t;
  item_t sbq[$];
  item_t cur;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  // Requirement model: sample history, output level, times of accepted changes
  logic [2:0] mh [3];
  logic       mo [3];
  int         mt [3][2];

  task automatic model_edge(input int k, input logic [2:0] inv, input logic r,
                            output logic [2:0] exp);
    for (int l = 0; l < 3; l++) begin
      if (!r) begin
        mh[l] = {3{inv[l]}};
        mo[l] = inv[l];
        mt[l][0] = -100000;
        mt[l][1] = -100000;
      end else begin
        logic ok;
        int   n;
        ok = (mode == 2'b11) ? (mh[l] == 3'b000 || mh[l] == 3'b111) : 1'b1;
        n  = (l == 2) ? 1 : 2;
        if (ok && mh[l][0] != mo[l]) begin
          if (!mode[1] || (k - mt[l][n-1] >= WIN)) begin
            mo[l] = mh[l][0];
            if (mode[1]) begin
              mt[l][1] = mt[l][0];
              mt[l][0] = k;
            end
          end
        end
        mh[l] = {mh[l][1:0], inv[l]};
      end
      exp[l] = mo[l];
    end
  endtask

  // Driver: apply one sample, predict the outputs after the coming edge
  task automatic step(input logic d, input logic h, input logic v, input logic r,
                      input string tag);
    logic [2:0] e;
    item_t it;
    @(posedge clk);
    #2;
    de_i = d; hs_i = h; vs_i = v; rst_n = r; mode = next_mode;
    model_edge(cyc + 1, {v, h, d}, r, e);
    it.exp = e;
    it.due = cyc + 1;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic hold(input logic d, input logic h, input logic v, input int n,
                      input string tag);
    for (int i = 0; i < n; i++) step(d, h, v, 1'b1, tag);
  endtask

  task automatic rst_seq(input logic [1:0] md, input logic d, input logic h,
                         input logic v);
    next_mode = md;
    for (int i = 0; i < 4; i++) step(d, h, v, 1'b0, "R9 reset");
  endtask

  // Monitor: compare each queued item at the falling edge after its edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        cur = sbq.pop_front();
        checks++;
        if ({vs_o, hs_o, de_o} !== cur.exp) begin
          errors++;
          $display("FAIL %s at edge %0d: vs/hs/de got %b expected %b",
                   cur.tag, cur.due, {vs_o, hs_o, de_o}, cur.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [7:0] lf;

  initial begin
    // R9: reset levels, then mode 2'b10 (filter off)
    rst_seq(2'b10, 1'b1, 1'b0, 1'b1);
    hold(1, 0, 1, 3, "R9 levels");
    hold(0, 0, 1, 5, "R3 first");
    hold(1, 0, 1, 1, "R3 one-cycle pulse");
    hold(0, 0, 1, 6, "R3 pulse end");
    hold(1, 0, 1, 1, "R4 de over budget");
    hold(0, 0, 1, 8, "R4 de held");
    for (int i = 0; i < 7; i++) hold(0, (i % 2 == 0), 1, 1, "R4 hs toggles");
    hold(0, 1, 0, 20, "R5 vs fall");
    hold(0, 1, 1, 150, "R5 R8 vs rise deferred");
    hold(0, 0, 1, 2, "R4 hs burn");
    hold(0, 1, 1, 2, "R4 hs burn");
    // R9: first change after reset accepted despite a spent budget
    rst_seq(2'b10, 1'b0, 1'b0, 1'b1);
    hold(0, 1, 1, 1, "R9 first after reset");
    hold(0, 0, 1, 6, "R9 second after reset");

    // Mode 2'b11: filter on
    rst_seq(2'b11, 1'b0, 1'b0, 1'b0);
    hold(0, 0, 0, 5, "R7 idle");
    hold(1, 0, 0, 1, "R6 width one");
    hold(0, 0, 0, 6, "R6 gap");
    hold(1, 0, 0, 2, "R6 width two");
    hold(0, 0, 0, 6, "R6 gap");
    hold(1, 0, 0, 3, "R6 width three");
    hold(0, 0, 0, 8, "R6 fall");
    hold(0, 0, 0, 140, "R4 window");
    hold(1, 1, 1, 10, "R7 aligned rise");
    hold(1, 1, 0, 2, "R6 vs glitch");
    hold(1, 1, 1, 5, "R6 vs restored");
    hold(1, 0, 1, 4, "R4 hs pulse");
    hold(1, 1, 1, 4, "R4 hs pulse");
    hold(1, 0, 1, 4, "R4 hs third");
    hold(1, 0, 1, 140, "R4 R8 hs deferred");

    // Legacy modes
    lf = 8'hA5;
    rst_seq(2'b00, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[0], lf[3], lf[6], 1'b1, "R1 R2 legacy 00");
    end
    rst_seq(2'b01, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 60; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf[2], lf[5], lf[1], 1'b1, "R1 R2 legacy 01");
    end

    repeat (4) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule